// File: doc/BRIEF.md
# Segmented message record/playback sequencer

This block is the digital control core of a single-chip voice message recorder whose storage is split into a fixed number of equal-length segments (160 by default). A falling edge on the active-low chip enable samples a record/playback select and an 8-bit address/mode word. The block then runs a record or playback operation and moves an internal segment pointer forward once per segment-tick strobe. The sample storage uses that pointer as its row address. End-of-message markers are held in a separate one-bit-per-segment memory. A record operation writes a marker where it stops, and a playback operation stops when it reaches one.

When both high bits of the address/mode word are set, the low six bits become option flags instead of an address. There are six options: fast message cueing, merging of sequential recordings, cascade signalling, looping, consecutive addressing and level-sensitive playback enable. The block also drives an active-low end-of-message pulse, a select for the auxiliary speaker input and the two activity flags. It watches a low-supply flag, which locks the block into playback only.

Top module: `msg_sequencer`

## Requirements
- R1: After reset the pointer is 0, no operation is active, `eomN` is 1, and `auxSel` is 1 whenever chip enable is high and nothing is active, or the overflow flag is set. `auxSel` is 0 while recording.
- R2: A start needs all of the following: the clock edge sees `ceN` low after it was high, `powerDown` is low, the block is idle and the overflow flag is clear. `addrMode[7:6]` other than 2'b11 is a direct start segment. A value of 160 or more starts nothing. The pointer always stays below 160.
- R3: `playSel`=0 selects record. Each tick while recording clears the marker of the current segment and advances the pointer. Recording ends when `ceN`, `powerDown` or `lowSupply` is high. The marker of the current segment is then set and the pointer moves one segment on, holding at 159. An end and a tick in the same cycle act as an end only.
- R4: `playSel`=1 selects playback. By default `ceN` going high does not stop playback. On each tick, a set marker at the current segment ends playback, starts an `eomN` low pulse of EOM_CYCLES clocks and clears the pointer to 0. Otherwise the pointer advances. A marker on segment 159 is a normal end, not an overflow.
- R5: A tick at segment 159 with no marker (while playing, recording or cueing) stops the operation and holds the pointer at 159. It also sets a sticky overflow flag and pulses `eomN`. Starts are then ignored.
- R6: `powerDown` high aborts any operation and clears the pointer and the overflow flag. A record that it aborts still writes its marker.
- R7: Mode word 2'b11 in `addrMode[7:6]` selects option flags: bit0 cueing, bit1 merge, bit2 cascade, bit3 loop, bit4 consecutive, bit5 level enable. A mode start begins at the current pointer. It begins at 0 instead when the last start was a record and this one is playback, or when playback has the loop or level flag.
- R8: Cueing (bit0, playback) moves the pointer one segment per clock without playing. It stops one past the first marker it finds.
- R9: Merge (bit1, record) clears the marker just before the start segment. Two sequential recordings then play back as one message.
- R10: Cascade (bit2) suppresses the end-of-message pulse at a marker. Playback still ends there.
- R11: Loop (bit3) returns the pointer to 0 at a marker and keeps playing. The end-of-message pulse is still given.
- R12: Consecutive (bit4) moves the pointer one past the marker at a playback end instead of clearing it.
- R13: Level enable (bit5) makes playback stop as soon as `ceN` goes high, keeping the pointer. The next start begins at segment 0.
- R14: `lowSupply` high holds `eomN` low, ends any recording and turns a record request into playback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Active-low chip enable; a falling edge starts an operation |
| powerDown | input | 1 | High aborts, clears the pointer and overflow |
| playSel | input | 1 | 1 playback, 0 record; sampled at start |
| addrMode | input | 8 | Start segment, or option flags when bits 7:6 are 11 |
| segTick | input | 1 | One-clock strobe at each segment boundary |
| lowSupply | input | 1 | Low-supply flag |
| segPtr | output | 8 | Current segment pointer |
| recActive | output | 1 | Record operation running |
| playActive | output | 1 | Playback operation running |
| eomN | output | 1 | Active-low end-of-message / overflow pulse |
| auxSel | output | 1 | Selects the auxiliary input for the speaker |

## Verification
Two pairs of events can land in the same clock. In the first, a segment tick arrives in the same cycle that chip enable rises during a record. The bench provokes this by raising `ceN` together with `segTick`. It judges the result by playing from the same start and requiring an end on the first tick, with the pointer one past the start after the record. In the second, a marker and the end of the array meet at segment 159. The bench records a zero-length message there and plays it back. It requires a normal end (pointer 0 and `auxSel` low with enable held low) rather than an overflow, which would hold 159 and raise `auxSel`.

// File: rtl/msg_seq_pkg.sv
package msg_seq_pkg;

  localparam int MODE_W = 6;

  // option flag positions inside the mode word
  localparam int MB_CUE     = 0;
  localparam int MB_MERGE   = 1;
  localparam int MB_CASCADE = 2;
  localparam int MB_LOOP    = 3;
  localparam int MB_CONSEC  = 4;
  localparam int MB_LEVEL   = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REC  = 2'd1,
    ST_PLAY = 2'd2,
    ST_CUE  = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ptrClr;
    logic ptrLoad;
    logic ptrInc;
    logic mkSet;
    logic mkClr;
    logic mkClrPrev;
    logic eomFire;
    logic ovfSet;
    logic ovfClr;
  } seqStrobes_t;

endpackage

// File: rtl/msg_seq_dp.sv
module msg_seq_dp
  import msg_seq_pkg::*;
#(
  parameter int SEG_COUNT  = 160,
  parameter int EOM_CYCLES = 4,
  parameter int PTR_W      = $clog2(SEG_COUNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobes_t      strb,
  input  logic [PTR_W-1:0] loadVal,
  input  logic             lowSupply,
  output logic [PTR_W-1:0] segPtr,
  output logic             markerHere,
  output logic             ovfFlag,
  output logic             eomN
);

  localparam int CNT_W = $clog2(EOM_CYCLES + 1);

  logic [SEG_COUNT-1:0] markers;
  logic [CNT_W-1:0]     eomCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              segPtr <= '0;
    else if (strb.ptrClr)   segPtr <= '0;
    else if (strb.ptrLoad)  segPtr <= loadVal;
    else if (strb.ptrInc)   segPtr <= segPtr + 1'b1;
  end

  // one marker bit per segment
  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_mark
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        markers[g] <= 1'b0;
      end else if (segPtr == PTR_W'(g)) begin
        if (strb.mkSet)      markers[g] <= 1'b1;
        else if (strb.mkClr) markers[g] <= 1'b0;
      end else if (strb.mkClrPrev && (segPtr == PTR_W'(g + 1))) begin
        markers[g] <= 1'b0;
      end
    end
  end

  always_comb begin
    if (int'(segPtr) < SEG_COUNT) markerHere = markers[segPtr];
    else                          markerHere = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ovfFlag <= 1'b0;
    else if (strb.ovfClr) ovfFlag <= 1'b0;
    else if (strb.ovfSet) ovfFlag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              eomCnt <= '0;
    else if (strb.eomFire)  eomCnt <= CNT_W'(EOM_CYCLES);
    else if (eomCnt != '0)  eomCnt <= eomCnt - 1'b1;
  end

  assign eomN = !(lowSupply || (eomCnt != '0));

endmodule

// File: rtl/msg_seq_ctrl.sv
module msg_seq_ctrl
  import msg_seq_pkg::*;
#(
  parameter int SEG_COUNT = 160,
  parameter int PTR_W     = $clog2(SEG_COUNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             powerDown,
  input  logic             playSel,
  input  logic [7:0]       addrMode,
  input  logic             segTick,
  input  logic             lowSupply,
  input  logic [PTR_W-1:0] segPtr,
  input  logic             markerHere,
  input  logic             ovfFlag,
  output seqStrobes_t      strb,
  output logic [PTR_W-1:0] loadVal,
  output logic             recActive,
  output logic             playActive,
  output logic             busy
);

  localparam logic [PTR_W-1:0] LAST_SEG = PTR_W'(SEG_COUNT - 1);

  seqState_t         state, nextState;
  logic              ceQ;
  logic [MODE_W-1:0] modeBits;
  logic              lastWasRec;

  logic isMode, dirPlay, ceFall, startOk, atLast;
  logic [PTR_W-1:0] startVal;

  assign isMode  = &addrMode[7:6];
  assign dirPlay = playSel | lowSupply;
  assign ceFall  = ceQ & ~ceN;
  assign atLast  = (segPtr == LAST_SEG);
  assign startOk = ceFall && !powerDown && !ovfFlag && (state == ST_IDLE) &&
                   (isMode || (int'(addrMode) < SEG_COUNT));

  always_comb begin
    if (isMode) begin
      if (dirPlay && (addrMode[MB_LOOP] || addrMode[MB_LEVEL])) startVal = '0;
      else if (dirPlay && lastWasRec)                          startVal = '0;
      else                                                     startVal = segPtr;
    end else begin
      startVal = PTR_W'(addrMode);
    end
  end

  always_comb begin
    strb      = '0;
    loadVal   = startVal;
    nextState = state;
    if (powerDown) begin
      strb.ptrClr = 1'b1;
      strb.ovfClr = 1'b1;
      if (state == ST_REC) strb.mkSet = 1'b1;
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startOk) begin
            strb.ptrLoad = 1'b1;
            if (!dirPlay) begin
              nextState = ST_REC;
              if (isMode && addrMode[MB_MERGE] && (segPtr != '0))
                strb.mkClrPrev = 1'b1;
            end else if (isMode && addrMode[MB_CUE]) begin
              nextState = ST_CUE;
            end else begin
              nextState = ST_PLAY;
            end
          end
        end
        ST_REC: begin
          if (ceN || lowSupply) begin
            strb.mkSet = 1'b1;
            if (!atLast) strb.ptrInc = 1'b1;
            nextState = ST_IDLE;
          end else if (segTick) begin
            strb.mkClr = 1'b1;
            if (atLast) begin
              strb.ovfSet  = 1'b1;
              strb.eomFire = 1'b1;
              nextState    = ST_IDLE;
            end else begin
              strb.ptrInc = 1'b1;
            end
          end
        end
        ST_PLAY: begin
          if (modeBits[MB_LEVEL] && ceN) begin
            nextState = ST_IDLE;
          end else if (segTick) begin
            if (markerHere) begin
              if (!modeBits[MB_CASCADE]) strb.eomFire = 1'b1;
              if (modeBits[MB_LOOP]) begin
                strb.ptrClr = 1'b1;
              end else begin
                if (!modeBits[MB_CONSEC]) strb.ptrClr = 1'b1;
                else if (!atLast)         strb.ptrInc = 1'b1;
                nextState = ST_IDLE;
              end
            end else if (atLast) begin
              strb.ovfSet  = 1'b1;
              strb.eomFire = 1'b1;
              nextState    = ST_IDLE;
            end else begin
              strb.ptrInc = 1'b1;
            end
          end
        end
        ST_CUE: begin
          if (markerHere) begin
            if (!atLast) strb.ptrInc = 1'b1;
            nextState = ST_IDLE;
          end else if (atLast) begin
            strb.ovfSet  = 1'b1;
            strb.eomFire = 1'b1;
            nextState    = ST_IDLE;
          end else begin
            strb.ptrInc = 1'b1;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      ceQ        <= 1'b1;
      modeBits   <= '0;
      lastWasRec <= 1'b0;
    end else begin
      state <= nextState;
      ceQ   <= ceN;
      if (startOk && (state == ST_IDLE)) begin
        modeBits   <= isMode ? addrMode[MODE_W-1:0] : '0;
        lastWasRec <= ~dirPlay;
      end
    end
  end

  assign recActive  = (state == ST_REC);
  assign playActive = (state == ST_PLAY);
  assign busy       = (state != ST_IDLE);

endmodule

// File: rtl/msg_sequencer.sv
module msg_sequencer
  import msg_seq_pkg::*;
#(
  parameter int SEG_COUNT  = 160,
  parameter int EOM_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       powerDown,
  input  logic       playSel,
  input  logic [7:0] addrMode,
  input  logic       segTick,
  input  logic       lowSupply,
  output logic [7:0] segPtr,
  output logic       recActive,
  output logic       playActive,
  output logic       eomN,
  output logic       auxSel
);

  localparam int PTR_W = 8;

  seqStrobes_t      strb;
  logic [PTR_W-1:0] loadVal;
  logic             markerHere, ovfFlag, busy;

  msg_seq_ctrl #(.SEG_COUNT(SEG_COUNT), .PTR_W(PTR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .powerDown(powerDown),
    .playSel(playSel), .addrMode(addrMode), .segTick(segTick),
    .lowSupply(lowSupply), .segPtr(segPtr), .markerHere(markerHere),
    .ovfFlag(ovfFlag), .strb(strb), .loadVal(loadVal),
    .recActive(recActive), .playActive(playActive), .busy(busy)
  );

  msg_seq_dp #(.SEG_COUNT(SEG_COUNT), .EOM_CYCLES(EOM_CYCLES), .PTR_W(PTR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal),
    .lowSupply(lowSupply), .segPtr(segPtr), .markerHere(markerHere),
    .ovfFlag(ovfFlag), .eomN(eomN)
  );

  assign auxSel = (ceN && !busy) || ovfFlag;

endmodule

// File: rtl/msg_seq_chk.sv
module msg_seq_chk #(
  parameter int SEG_COUNT = 160
) (
  input logic       clk,
  input logic       rstN,
  input logic       ceN,
  input logic       powerDown,
  input logic       segTick,
  input logic       lowSupply,
  input logic [7:0] segPtr,
  input logic       recActive,
  input logic       auxSel
);

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(segPtr) < SEG_COUNT); // R2

  AST_REC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (recActive && segTick && !ceN && !powerDown && !lowSupply &&
     (int'(segPtr) < SEG_COUNT - 1)) |=> (segPtr == $past(segPtr) + 8'd1)); // R3

  AST_PD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> (segPtr == 8'd0)); // R6

  AST_LOW_NO_REC: assert property (@(posedge clk) disable iff (!rstN)
    lowSupply |=> !recActive); // R14

  AST_REC_NO_AUX: assert property (@(posedge clk) disable iff (!rstN)
    recActive |-> !auxSel); // R1

endmodule

bind msg_sequencer msg_seq_chk #(.SEG_COUNT(SEG_COUNT)) i_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .powerDown(powerDown),
  .segTick(segTick), .lowSupply(lowSupply), .segPtr(segPtr),
  .recActive(recActive), .auxSel(auxSel)
);

// File: tb/test_msg_sequencer.sv
`timescale 1ns/100ps
module test_msg_sequencer;

  localparam int K_PTR = 0, K_EOM = 1, K_AUX = 2, K_REC = 3, K_PLAY = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, powerDown = 1'b0, playSel = 1'b0, segTick = 1'b0, lowSupply = 1'b0;
  logic [7:0] addrMode = 8'd0;
  logic [7:0] segPtr;
  logic recActive, playActive, eomN, auxSel;

  int checks = 0, errors = 0, negCount = 0;
  bit finished = 0;

  typedef struct { int cyc; int kind; int val; string tag; } expItem_t;
  expItem_t sbq[$];

  always #2.5 clk = ~clk;

  msg_sequencer i_msg_sequencer (
    .clk(clk), .rstN(rstN), .ceN(ceN), .powerDown(powerDown), .playSel(playSel),
    .addrMode(addrMode), .segTick(segTick), .lowSupply(lowSupply),
    .segPtr(segPtr), .recActive(recActive), .playActive(playActive),
    .eomN(eomN), .auxSel(auxSel)
  );

  function automatic int actual(int kind);
    case (kind)
      K_PTR:   return int'(segPtr);
      K_EOM:   return int'(eomN);
      K_AUX:   return int'(auxSel);
      K_REC:   return int'(recActive);
      default: return int'(playActive);
    endcase
  endfunction

  // driver side: queue an expectation d negedges ahead
  task automatic ex(int d, int kind, int val, string tag);
    expItem_t it;
    it.cyc = negCount + d; it.kind = kind; it.val = val; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // monitor side
  always @(negedge clk) begin
    #0.5;
    negCount++;
    while (sbq.size() > 0 && sbq[0].cyc <= negCount) begin
      expItem_t it;
      it = sbq.pop_front();
      checks++;
      if (actual(it.kind) != it.val) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.tag, it.kind,
                 actual(it.kind), it.val);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  task automatic tickExpPtr(int p, string tag);
    segTick = 1'b1; ex(1, K_PTR, p, tag); step(); segTick = 1'b0;
  endtask

  task automatic pdPulse();
    ceN = 1'b1; powerDown = 1'b1; step(); powerDown = 1'b0; step();
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    ex(1, K_PTR, 0, "R1 reset ptr"); ex(1, K_EOM, 1, "R1 reset eom");
    ex(1, K_AUX, 1, "R1 reset aux"); ex(1, K_REC, 0, "R1 reset rec");
    ex(1, K_PLAY, 0, "R1 reset play");
    step();

    // direct record at 10, three segments
    playSel = 0; addrMode = 8'd10; ceN = 0;
    ex(1, K_REC, 1, "R2 record start"); ex(1, K_PTR, 10, "R2 start ptr");
    ex(1, K_AUX, 0, "R1 aux off recording");
    step();
    tickExpPtr(11, "R3 rec tick"); tickExpPtr(12, "R3 rec tick"); tickExpPtr(13, "R3 rec tick");
    ceN = 1;
    ex(1, K_REC, 0, "R3 rec end"); ex(1, K_PTR, 14, "R3 ptr after end");
    ex(1, K_AUX, 1, "R1 aux idle");
    step();

    // direct playback at 10, edge mode
    playSel = 1; addrMode = 8'd10; ceN = 0;
    ex(1, K_PLAY, 1, "R4 play start"); ex(1, K_PTR, 10, "R4 play ptr");
    step();
    ceN = 1; ex(1, K_PLAY, 1, "R4 edge enable keeps playing"); ex(1, K_AUX, 0, "R1 aux off playing");
    step();
    tickExpPtr(11, "R4 play tick"); tickExpPtr(12, "R4 play tick"); tickExpPtr(13, "R4 play tick");
    segTick = 1;
    ex(1, K_PLAY, 0, "R4 stop at marker"); ex(1, K_PTR, 0, "R4 ptr cleared");
    ex(1, K_AUX, 1, "R1 aux after play");
    for (int d = 1; d <= 4; d++) ex(d, K_EOM, 0, "R4 eom pulse low");
    ex(5, K_EOM, 1, "R4 eom pulse end");
    step(); segTick = 0; step(5);

    // overflow during playback
    playSel = 1; addrMode = 8'd158; ceN = 0;
    ex(1, K_PTR, 158, "R2 start 158"); step();
    tickExpPtr(159, "R5 play to last");
    segTick = 1;
    ex(1, K_PLAY, 0, "R5 overflow stop"); ex(1, K_PTR, 159, "R5 ptr holds");
    ex(1, K_AUX, 1, "R5 aux at overflow"); ex(1, K_EOM, 0, "R5 overflow eom");
    step(); segTick = 0; step(5);
    ceN = 1; step();
    ceN = 0; ex(1, K_PLAY, 0, "R5 start ignored"); ex(1, K_PTR, 159, "R5 ptr kept");
    step();
    ceN = 1; powerDown = 1; ex(1, K_PTR, 0, "R6 pd clears ptr"); step();
    powerDown = 0; ceN = 0; playSel = 1; addrMode = 8'd50;
    ex(1, K_PLAY, 1, "R6 overflow cleared"); step();
    powerDown = 1; ceN = 1; step(); powerDown = 0; step();

    // tick and enable-high in the same cycle while recording
    playSel = 0; addrMode = 8'd20; ceN = 0; step();
    segTick = 1; ceN = 1; ex(1, K_PTR, 21, "R3 end wins over tick"); ex(1, K_REC, 0, "R3 end same cycle");
    step(); segTick = 0;
    playSel = 1; addrMode = 8'd20; ceN = 0; step(); ceN = 1; step();
    segTick = 1; ex(1, K_PLAY, 0, "R3 marker at tie segment"); ex(1, K_PTR, 0, "R3 tie ptr");
    step(); segTick = 0; step(5);

    // marker on the last segment
    playSel = 0; addrMode = 8'd159; ceN = 0; step();
    ceN = 1; ex(1, K_PTR, 159, "R3 ptr holds at last"); step();
    playSel = 1; ceN = 0; step();
    segTick = 1; ex(1, K_PTR, 0, "R4 last marker normal end"); ex(1, K_AUX, 0, "R4 not overflow");
    step(); segTick = 0; step(5);
    ceN = 1; step();

    // power-down aborts a record
    playSel = 0; addrMode = 8'd40; ceN = 0; step();
    powerDown = 1; ex(1, K_REC, 0, "R6 pd aborts rec"); ex(1, K_PTR, 0, "R6 pd ptr");
    step(); powerDown = 0; ceN = 1; step();

    // consecutive mode, two records then two playbacks
    playSel = 0; addrMode = 8'hD0; ceN = 0; ex(1, K_PTR, 0, "R7 mode rec start"); step();
    tickExpPtr(1, "R12 rec"); tickExpPtr(2, "R12 rec");
    ceN = 1; ex(1, K_PTR, 3, "R12 rec end"); step();
    ceN = 0; ex(1, K_PTR, 3, "R7 mode start at ptr"); step();
    tickExpPtr(4, "R12 rec2");
    ceN = 1; ex(1, K_PTR, 5, "R12 rec2 end"); step();
    playSel = 1; ceN = 0; ex(1, K_PTR, 0, "R7 rec to play resets"); ex(1, K_PLAY, 1, "R7 play"); step();
    ceN = 1; step();
    tickExpPtr(1, "R12 play"); tickExpPtr(2, "R12 play");
    segTick = 1; ex(1, K_PLAY, 0, "R12 end msg1"); ex(1, K_PTR, 3, "R12 ptr kept past marker");
    step(); segTick = 0;
    ceN = 0; ex(1, K_PTR, 3, "R12 next msg start"); step(); ceN = 1; step();
    tickExpPtr(4, "R12 play2");
    segTick = 1; ex(1, K_PTR, 5, "R12 end msg2"); step(); segTick = 0; step(5);

    // cueing
    pdPulse();
    playSel = 1; addrMode = 8'hC1; ceN = 0; step(4);
    ex(1, K_PTR, 3, "R8 cue to next msg"); ex(1, K_PLAY, 0, "R8 cue silent"); step();
    ceN = 1; step(); ceN = 0; step(3);
    ex(1, K_PTR, 5, "R8 cue second"); step();
    ceN = 1; step();

    // merge of sequential records
    pdPulse();
    playSel = 0; addrMode = 8'hD2; ceN = 0; step();
    tickExpPtr(1, "R9 rec");
    ceN = 1; ex(1, K_PTR, 2, "R9 rec end"); step();
    ceN = 0; step();
    tickExpPtr(3, "R9 rec2");
    ceN = 1; ex(1, K_PTR, 4, "R9 rec2 end"); step();
    playSel = 1; addrMode = 8'hD0; ceN = 0; step(); ceN = 1; step();
    tickExpPtr(1, "R9 play"); tickExpPtr(2, "R9 play");
    segTick = 1; ex(1, K_PLAY, 1, "R9 merged marker gone"); ex(1, K_PTR, 3, "R9 ptr"); step(); segTick = 0;
    segTick = 1; ex(1, K_PLAY, 0, "R9 end of merged msg"); ex(1, K_PTR, 4, "R9 end ptr");
    step(); segTick = 0; step(5);

    // cascade: quiet end
    playSel = 1; addrMode = 8'hC4; ceN = 0; ex(1, K_PTR, 4, "R10 start"); step(); ceN = 1; step();
    segTick = 1; ex(1, K_PLAY, 0, "R10 end"); ex(1, K_EOM, 1, "R10 no pulse"); ex(2, K_EOM, 1, "R10 no pulse");
    step(); segTick = 0; step();

    // loop
    playSel = 1; addrMode = 8'hC8; ceN = 0; ex(1, K_PTR, 0, "R11 loop start"); step(); ceN = 1; step();
    tickExpPtr(1, "R11"); tickExpPtr(2, "R11"); tickExpPtr(3, "R11");
    segTick = 1; ex(1, K_PLAY, 1, "R11 keeps playing"); ex(1, K_PTR, 0, "R11 back to 0");
    ex(1, K_EOM, 0, "R11 pulse given");
    step(); segTick = 0;
    powerDown = 1; ex(1, K_PLAY, 0, "R6 pd stops loop"); step(); powerDown = 0; step(5);

    // level enable
    playSel = 1; addrMode = 8'hE0; ceN = 0; ex(1, K_PLAY, 1, "R13 start"); step();
    tickExpPtr(1, "R13 tick");
    ceN = 1; ex(1, K_PLAY, 0, "R13 stop on high"); ex(1, K_PTR, 1, "R13 ptr kept"); step();
    ceN = 0; ex(1, K_PLAY, 1, "R13 restart"); ex(1, K_PTR, 0, "R13 from 0"); step();
    ceN = 1; step();

    // invalid direct address 170
    playSel = 1; addrMode = 8'hAA; ceN = 0;
    ex(1, K_PLAY, 0, "R2 invalid addr ignored"); ex(1, K_REC, 0, "R2 invalid no rec");
    ex(1, K_PTR, 0, "R2 ptr unchanged"); step();
    ceN = 1; step();

    // low supply
    lowSupply = 1; ex(1, K_EOM, 0, "R14 eom held low"); step();
    playSel = 0; addrMode = 8'd30; ceN = 0;
    ex(1, K_REC, 0, "R14 record refused"); ex(1, K_PLAY, 1, "R14 forced play");
    ex(1, K_PTR, 30, "R14 start ptr"); step();
    ceN = 1; step();
    powerDown = 1; step(); powerDown = 0; lowSupply = 0; step(5);
    ex(1, K_EOM, 1, "R14 eom released"); step();

    step(2);
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sbq.size());
    end
    summary();
  end

endmodule